// File: doc/BRIEF.md
# Match/Compare Timer with PWM Outputs

This block is a 16-bit counter/timer with a programmable prescaler and four compare channels. The counter advances either on every clock or on rising edges of a capture pin. It counts up with wrap, counts down with reload, or counts up and back down (center-aligned). Channel 3's compare value sets the period in every counting mode. Each channel compares its value against the counter. When the counter arrives at a channel's value, the channel can raise a sticky interrupt flag, stop the timer, or drive a match output that is cleared, set or toggled. A channel can also give a PWM level, or hand its pin to a plain software-driven value.

Compare values pass through shadow registers. They are copied in while the timer is stopped, at each period boundary, or while the shadowed period is zero. A duty-cycle change written mid-period therefore takes effect from the next period. Software controls the block through pulse inputs: start, halt, counter clear and per-channel flag clear.

Top module: `mct_timer`

## Requirements
- R1: After reset, count is 0, running is 0, all flags and irq are 0, and every match-action level is 0.
- R2: In clock-source mode with prescale value N, a running counter moves once every N+1 clocks. The first move comes N+1 clocks after the start edge. While running is 0, count holds.
- R3: With src_sel=1 the prescaler advances only in a cycle where cap_in is 1 and was 0 in the previous cycle. Holding cap_in high produces no further counts.
- R4: Mode 2'b00 (and the spare code 2'b11) counts up from 0 to the period P (the channel 3 shadow) and then wraps to 0.
- R5: Mode 2'b01 counts down to 0 and then reloads P. A cnt_clear pulse loads P in this mode and 0 in the other modes.
- R6: Mode 2'b10 counts 0 up to P and back down to 0, repeating. The counter holds while P is 0.
- R7: When counting brings the counter onto a channel's shadow value, the following edge acts on the enables for that channel. stop_en clears running, and the counter stays on the match value. rst_en makes the next count move go to the start value (P in mode 01, otherwise 0) instead of continuing.
- R8: On an arrival with irq_en, the channel's flag is set on the next edge. A 1 in flag_clr clears the flag, and a 0 leaves it. A set and a clear in the same cycle leave the flag set. irq is the OR of the flags.
- R9: A new match_val is copied to the shadow only while running is 0, on the edge where the counter returns to its start value by wrap or match reset, or while the shadow period is 0. A value written mid-period has no effect on outputs until then.
- R10: With pwm_en=1 the channel level is 1 while count is below the shadow value and 0 otherwise. A value above P gives a level that is high for the whole period.
- R11: With pwm_en=0 the channel level is a match register that changes on each arrival per ext_act: 00 hold, 01 clear, 10 set, 11 toggle.
- R12: With out_en=0, pin_out follows gpio_val. With out_en=1, pin_out shows the channel's timer level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_start | input | 1 | Pulse: set running |
| tmr_halt | input | 1 | Pulse: clear running |
| cnt_clear | input | 1 | Pulse: load counter with start value, clear prescaler |
| cnt_mode | input | 2 | 00 up, 01 down, 10 center, 11 up |
| src_sel | input | 1 | 0 count clocks, 1 count capture rising edges |
| cap_in | input | 1 | Capture pin used as count source |
| pre_val | input | 16 | Prescale value N (divide by N+1) |
| match_val | input | 64 | Four 16-bit compare values, channel k at bits 16k+15:16k |
| irq_en | input | 4 | Per-channel flag enable |
| rst_en | input | 4 | Per-channel counter reset on match |
| stop_en | input | 4 | Per-channel stop on match |
| pwm_en | input | 4 | Per-channel PWM level instead of match register |
| ext_act | input | 8 | Per-channel match action, channel k at bits 2k+1:2k |
| out_en | input | 4 | Per-channel pin source: 1 timer, 0 gpio_val |
| gpio_val | input | 4 | Per-channel software pin value |
| flag_clr | input | 4 | Per-channel write-1 flag clear |
| count | output | 16 | Current counter value |
| running | output | 1 | Timer enable state |
| flags | output | 4 | Sticky match flags |
| irq | output | 1 | OR of flags |
| pin_out | output | 4 | Channel pin levels |

## Verification
The bench targets the one-clock delay of stop-on-match. A design that lets the counter step once more would end one count past the match value, and one that acts early would clear running too soon. It writes a compare value mid-period to catch a missing shadow, which would move the PWM edge inside the current period. It also sets a compare value beyond the period, where a plain compare would still give the expected high level. It clears with the wrong bit and with the right bit, and holds the capture pin high to expose a level-sensitive count source. Down-mode clear, and center mode with a zero period, would show as a counter loaded with 0 or drifting away from 0.

// File: rtl/mct_pkg.sv
package mct_pkg;
    typedef enum logic [1:0] {
        CM_UP     = 2'b00,
        CM_DOWN   = 2'b01,
        CM_CENTER = 2'b10,
        CM_UP_ALT = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_CLEAR  = 2'b01,
        ACT_SET    = 2'b10,
        ACT_TOGGLE = 2'b11
    } ext_act_e;
endpackage

// File: rtl/mct_prescale.sv
module mct_prescale #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          hold,
    input  logic          clr,
    input  logic          src_sel,
    input  logic          cap_in,
    input  logic [CW-1:0] pre_val,
    output logic          step_o
);
    typedef struct packed {
        logic [CW-1:0] pc;
        logic          cap;
    } ps_t;

    ps_t  s_q, s_d;
    logic rise, tick;

    always_comb begin
        s_d     = s_q;
        s_d.cap = cap_in;
        rise    = cap_in & ~s_q.cap;
        tick    = run & ~hold & (src_sel ? rise : 1'b1);
        step_o  = 1'b0;
        if (clr) begin
            s_d.pc = '0;
        end else if (tick) begin
            if (s_q.pc >= pre_val) begin
                s_d.pc = '0;
                step_o = 1'b1;
            end else begin
                s_d.pc = s_q.pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a capture level held high never yields a count step
    p_level_no_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && s_q.cap && cap_in) |-> !step_o);
endmodule

// File: rtl/mct_counter.sv
module mct_counter
    import mct_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          step_in,
    input  logic [CW-1:0] period,
    input  logic          rst_req,
    input  logic          sw_rst,
    output logic [CW-1:0] count_o,
    output logic          upd_o,
    output logic          boundary_o
);
    typedef struct packed {
        logic [CW-1:0] count;
        logic          dir;
        logic          upd;
    } cnt_t;

    cnt_t          s_q, s_d;
    logic          center, down, step, dirn;
    logic [CW-1:0] start_v, nxt;

    always_comb begin
        center  = (mode == CM_CENTER);
        down    = (mode == CM_DOWN);
        start_v = down ? period : '0;
        step    = step_in & ~(center & (period == '0));
        nxt     = s_q.count;
        dirn    = s_q.dir;
        if (rst_req) begin
            nxt  = start_v;
            dirn = 1'b0;
        end else if (down) begin
            nxt = (s_q.count == '0) ? period : s_q.count - 1'b1;
        end else if (center) begin
            if (!s_q.dir) begin
                if (s_q.count >= period) begin
                    nxt  = s_q.count - 1'b1;
                    dirn = 1'b1;
                end else begin
                    nxt = s_q.count + 1'b1;
                end
            end else begin
                if (s_q.count == '0) begin
                    nxt  = CW'(1);
                    dirn = 1'b0;
                end else begin
                    nxt = s_q.count - 1'b1;
                end
            end
        end else begin
            nxt  = (s_q.count >= period) ? '0 : s_q.count + 1'b1;
            dirn = 1'b0;
        end

        boundary_o = step && (nxt == start_v);

        s_d = s_q;
        if (sw_rst) begin
            s_d.count = start_v;
            s_d.dir   = 1'b0;
            s_d.upd   = 1'b0;
        end else begin
            s_d.upd = step;
            if (step) begin
                s_d.count = nxt;
                s_d.dir   = dirn;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.count;
    assign upd_o   = s_q.upd;

    // R2: without a step request or a clear the counter holds
    p_hold_without_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_in && !sw_rst) |=> $stable(s_q.count));
    // R5: clear in down mode loads the period
    p_down_clear_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst && mode == CM_DOWN) |=> (s_q.count == $past(period)));
    // R6: center mode with zero period holds the counter
    p_center_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_CENTER && period == '0 && !sw_rst) |=> $stable(s_q.count));
endmodule

// File: rtl/mct_channel.sv
module mct_channel
    import mct_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] mr_in,
    input  logic          load,
    input  logic [CW-1:0] count,
    input  logic          upd,
    input  logic          run,
    input  logic          irq_en,
    input  logic          rst_en,
    input  logic          stop_en,
    input  logic          pwm_en,
    input  logic [1:0]    act,
    input  logic          oe,
    input  logic          gpio_val,
    input  logic          clr,
    output logic [CW-1:0] mr_sh_o,
    output logic          rst_req_o,
    output logic          stop_req_o,
    output logic          flag_o,
    output logic          pin_o
);
    typedef struct packed {
        logic [CW-1:0] mr_sh;
        logic          flag;
        logic          ext;
    } ch_t;

    ch_t  s_q, s_d;
    logic eq, arrive, pwm_lvl;

    always_comb begin
        eq         = (count == s_q.mr_sh);
        arrive     = upd & run & eq;
        rst_req_o  = rst_en & eq;
        stop_req_o = stop_en & arrive;
        pwm_lvl    = (count < s_q.mr_sh);

        s_d = s_q;
        if (load) s_d.mr_sh = mr_in;
        if (arrive && irq_en) s_d.flag = 1'b1;
        else if (clr)         s_d.flag = 1'b0;
        if (arrive) begin
            case (ext_act_e'(act))
                ACT_CLEAR:  s_d.ext = 1'b0;
                ACT_SET:    s_d.ext = 1'b1;
                ACT_TOGGLE: s_d.ext = ~s_q.ext;
                default:    s_d.ext = s_q.ext;
            endcase
        end
        pin_o = oe ? (pwm_en ? pwm_lvl : s_q.ext) : gpio_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mr_sh_o = s_q.mr_sh;
    assign flag_o  = s_q.flag;

    // R8: enabled arrival sets the flag on the next edge
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && irq_en) |=> s_q.flag);
    // R8: write-1 clear without a competing set clears the flag
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && clr && !(arrive && irq_en)) |=> !s_q.flag);
    // R9: shadow value changes only on a load cycle
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(s_q.mr_sh));
    // R11: toggle action flips the match level
    p_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && act == 2'b11) |=> (s_q.ext != $past(s_q.ext)));
endmodule

// File: rtl/mct_timer.sv
module mct_timer
    import mct_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_start,
    input  logic              tmr_halt,
    input  logic              cnt_clear,
    input  logic [1:0]        cnt_mode,
    input  logic              src_sel,
    input  logic              cap_in,
    input  logic [CW-1:0]     pre_val,
    input  logic [NCH*CW-1:0] match_val,
    input  logic [NCH-1:0]    irq_en,
    input  logic [NCH-1:0]    rst_en,
    input  logic [NCH-1:0]    stop_en,
    input  logic [NCH-1:0]    pwm_en,
    input  logic [2*NCH-1:0]  ext_act,
    input  logic [NCH-1:0]    out_en,
    input  logic [NCH-1:0]    gpio_val,
    input  logic [NCH-1:0]    flag_clr,
    output logic [CW-1:0]     count,
    output logic              running,
    output logic [NCH-1:0]    flags,
    output logic              irq,
    output logic [NCH-1:0]    pin_out
);
    localparam int PER_CH = NCH - 1;

    typedef struct packed {
        logic run;
    } top_t;

    top_t          s_q, s_d;
    logic [CW-1:0] mr_sh [NCH];
    logic [NCH-1:0] rst_req, stop_req;
    logic          stop_now, step, upd, boundary, load;
    logic [CW-1:0] period;

    assign period   = mr_sh[PER_CH];
    assign stop_now = |stop_req;
    assign load     = ~s_q.run | boundary | (period == '0);

    always_comb begin
        s_d = s_q;
        if (tmr_start)                 s_d.run = 1'b1;
        else if (tmr_halt || stop_now) s_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    mct_prescale #(.CW(CW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.run),
        .hold    (stop_now),
        .clr     (cnt_clear),
        .src_sel (src_sel),
        .cap_in  (cap_in),
        .pre_val (pre_val),
        .step_o  (step)
    );

    mct_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cnt_mode),
        .step_in    (step),
        .period     (period),
        .rst_req    (|rst_req),
        .sw_rst     (cnt_clear),
        .count_o    (count),
        .upd_o      (upd),
        .boundary_o (boundary)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        mct_channel #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .mr_in      (match_val[k*CW +: CW]),
            .load       (load),
            .count      (count),
            .upd        (upd),
            .run        (s_q.run),
            .irq_en     (irq_en[k]),
            .rst_en     (rst_en[k]),
            .stop_en    (stop_en[k]),
            .pwm_en     (pwm_en[k]),
            .act        (ext_act[2*k +: 2]),
            .oe         (out_en[k]),
            .gpio_val   (gpio_val[k]),
            .clr        (flag_clr[k]),
            .mr_sh_o    (mr_sh[k]),
            .rst_req_o  (rst_req[k]),
            .stop_req_o (stop_req[k]),
            .flag_o     (flags[k]),
            .pin_o      (pin_out[k])
        );
    end

    assign running = s_q.run;
    assign irq     = |flags;

    // R7: a stop arrival clears running on the next edge
    p_stop_clears_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_now && !tmr_start) |=> !running);
    // R7: the counter does not move past the match value that stopped it
    p_stop_holds_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_now && !cnt_clear) |=> $stable(count));
endmodule

// File: tb/mct_timer_test.sv
module mct_timer_test;
    localparam int CW  = 16;
    localparam int NCH = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              t_start, t_halt, t_clr, src, cap;
    logic [1:0]        mode;
    logic [CW-1:0]     pre;
    logic [CW-1:0]     mv [NCH];
    logic [NCH*CW-1:0] match_val;
    logic [NCH-1:0]    irq_en, rst_en, stop_en, pwm_en, out_en, gpio, fclr;
    logic [2*NCH-1:0]  act;
    logic [CW-1:0]     count;
    logic              running, irq;
    logic [NCH-1:0]    flags, pin_out;

    always_comb for (int k = 0; k < NCH; k++) match_val[k*CW +: CW] = mv[k];

    mct_timer #(.CW(CW), .NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .tmr_start(t_start), .tmr_halt(t_halt),
        .cnt_clear(t_clr), .cnt_mode(mode), .src_sel(src), .cap_in(cap),
        .pre_val(pre), .match_val(match_val), .irq_en(irq_en), .rst_en(rst_en),
        .stop_en(stop_en), .pwm_en(pwm_en), .ext_act(act), .out_en(out_en),
        .gpio_val(gpio), .flag_clr(fclr), .count(count), .running(running),
        .flags(flags), .irq(irq), .pin_out(pin_out)
    );

    int n_run  = 0;
    int n_fail = 0;

    // reference state
    logic [CW-1:0]  m_count, m_pc;
    logic           m_dir, m_upd, m_run, m_capq;
    logic [CW-1:0]  m_sh [NCH];
    logic [NCH-1:0] m_flag, m_ext;

    task automatic chk(input string tag, input int actual, input int expected);
        n_run++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic logic exp_pin(input int k);
        if (!out_en[k]) return gpio[k];
        if (pwm_en[k])  return (m_count < m_sh[k]);
        return m_ext[k];
    endfunction

    task automatic model_step();
        logic [CW-1:0] p, start_v, nxt, cnt_n, pc_n;
        logic dirn, dir_n, upd_n, run_n, stopnow, rise, tick, done, step, rreq, bnd, load;
        logic [NCH-1:0] eq, arr;
        p = m_sh[NCH-1];
        for (int k = 0; k < NCH; k++) begin
            eq[k]  = (m_count == m_sh[k]);
            arr[k] = m_upd & m_run & eq[k];
        end
        stopnow = |(arr & stop_en);
        rise    = cap & ~m_capq;
        tick    = m_run & ~stopnow & (src ? rise : 1'b1);
        done    = tick && (m_pc >= pre);
        pc_n    = t_clr ? '0 : (tick ? (done ? '0 : m_pc + 1'b1) : m_pc);
        step    = done && !(mode == 2'b10 && p == '0) && !t_clr;
        start_v = (mode == 2'b01) ? p : '0;
        rreq    = |(rst_en & eq);
        nxt  = m_count;
        dirn = m_dir;
        if (rreq) begin
            nxt = start_v; dirn = 1'b0;
        end else if (mode == 2'b01) begin
            nxt = (m_count == '0) ? p : m_count - 1'b1;
        end else if (mode == 2'b10) begin
            if (!m_dir) begin
                if (m_count >= p) begin nxt = m_count - 1'b1; dirn = 1'b1; end
                else nxt = m_count + 1'b1;
            end else begin
                if (m_count == '0) begin nxt = 16'd1; dirn = 1'b0; end
                else nxt = m_count - 1'b1;
            end
        end else begin
            nxt = (m_count >= p) ? '0 : m_count + 1'b1; dirn = 1'b0;
        end
        bnd = step && (nxt == start_v);
        if (t_clr) begin cnt_n = start_v; dir_n = 1'b0; upd_n = 1'b0; end
        else begin
            upd_n = step;
            cnt_n = step ? nxt : m_count;
            dir_n = step ? dirn : m_dir;
        end
        run_n = t_start ? 1'b1 : ((t_halt || stopnow) ? 1'b0 : m_run);
        load  = !m_run || bnd || (p == '0);
        for (int k = 0; k < NCH; k++) begin
            if (arr[k] && irq_en[k]) m_flag[k] = 1'b1;
            else if (fclr[k])        m_flag[k] = 1'b0;
            if (arr[k]) begin
                case (act[2*k +: 2])
                    2'b01: m_ext[k] = 1'b0;
                    2'b10: m_ext[k] = 1'b1;
                    2'b11: m_ext[k] = ~m_ext[k];
                    default: ;
                endcase
            end
            if (load) m_sh[k] = mv[k];
        end
        m_count = cnt_n; m_dir = dir_n; m_upd = upd_n; m_run = run_n;
        m_pc = pc_n; m_capq = cap;
    endtask

    task automatic compare_all();
        string ct;
        ct = (mode == 2'b01) ? "R5 down count" : (mode == 2'b10) ? "R6 center count" : "R4 up count";
        chk(ct, count, m_count);
        chk("R7 running", running, m_run);
        chk("R8 flags", flags, m_flag);
        chk("R8 irq", irq, |m_flag);
        for (int k = 0; k < NCH; k++) begin
            if (!out_en[k])     chk("R12 pin gpio", pin_out[k], exp_pin(k));
            else if (pwm_en[k]) chk("R10 pin pwm", pin_out[k], exp_pin(k));
            else                chk("R11 pin match", pin_out[k], exp_pin(k));
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(posedge clk);
            #2;
            compare_all();
        end
    endtask

    task automatic pulse_start();  t_start = 1'b1; cyc(1); t_start = 1'b0; endtask
    task automatic pulse_halt();   t_halt  = 1'b1; cyc(1); t_halt  = 1'b0; endtask
    task automatic pulse_clear();  t_clr   = 1'b1; cyc(1); t_clr   = 1'b0; endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int c;
        void'($urandom(32'd20240));
        rst_n = 1'b0;
        t_start = 0; t_halt = 0; t_clr = 0; src = 0; cap = 0; mode = 2'b00;
        pre = '0; irq_en = '0; rst_en = '0; stop_en = '0; pwm_en = '0;
        out_en = '0; gpio = '0; fclr = '0; act = '0;
        for (int k = 0; k < NCH; k++) begin mv[k] = '0; m_sh[k] = '0; end
        m_count = '0; m_pc = '0; m_dir = 0; m_upd = 0; m_run = 0; m_capq = 0;
        m_flag = '0; m_ext = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 running", running, 0);
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);
        out_en = '1; pwm_en = '0;
        #1 chk("R1 match levels", pin_out, 0);
        out_en = '0;

        // R2 prescale by 3
        pre = 16'd2; mv[3] = 16'd5;
        cyc(2); pulse_clear(); pulse_start();
        cyc(3); chk("R2 first step", count, 1);
        cyc(3); chk("R2 second step", count, 2);
        cyc(20); pulse_halt();
        c = count; cyc(5); chk("R2 halted hold", count, c);

        // R3 capture edges
        src = 1; pre = '0; cap = 0;
        pulse_clear(); pulse_start();
        cyc(1); cap = 1; cyc(1); chk("R3 edge counted", count, 1);
        cyc(4); chk("R3 level ignored", count, 1);
        cap = 0; cyc(1); cap = 1; cyc(1); chk("R3 second edge", count, 2);
        pulse_halt(); src = 0; cap = 0;

        // R5 down mode
        mode = 2'b01; mv[3] = 16'd9; cyc(2);
        pulse_clear(); chk("R5 clear loads period", count, 9);
        pulse_start(); cyc(25); pulse_halt();

        // R6 center, zero period then 4
        mode = 2'b10; mv[3] = '0; cyc(2);
        pulse_clear(); pulse_start(); cyc(5);
        chk("R6 zero period hold", count, 0);
        mv[3] = 16'd4; cyc(30); pulse_halt();

        // R7 stop on match, R8 flag
        mode = 2'b00; mv[3] = 16'd10; mv[0] = 16'd4; stop_en = 4'b0001; irq_en = 4'b0001;
        cyc(2); pulse_clear(); pulse_start(); cyc(10);
        chk("R7 stopped count", count, 4);
        chk("R7 stopped running", running, 0);
        chk("R8 flag set", flags[0], 1);

        // R8 write-1 clear
        fclr = 4'b0010; cyc(1); chk("R8 other bit no effect", flags[0], 1);
        fclr = 4'b0001; cyc(1); chk("R8 clear bit", flags[0], 0);
        fclr = '0; chk("R8 irq low", irq, 0);

        // R9 shadow, R10 beyond period, R11 toggle, R12 gpio
        stop_en = '0; irq_en = '0;
        mv[3] = 16'd7; mv[1] = 16'd3; mv[0] = 16'd20; mv[2] = 16'd2;
        pwm_en = 4'b0011; out_en = 4'b0111; act = 8'b00_11_00_00; gpio = 4'b1000;
        cyc(2); pulse_clear(); pulse_start();
        chk("R10 beyond period high", pin_out[0], 1);
        cyc(2); mv[1] = 16'd6;
        cyc(1); chk("R9 mid-period write ignored", pin_out[1], 0);
        cyc(5); chk("R9 wrapped", count, 0);
        cyc(4); chk("R9 new value in use", pin_out[1], 1);
        chk("R10 still high", pin_out[0], 1);
        chk("R12 gpio pin", pin_out[3], 1);
        cyc(20);
        rst_en = 4'b0010; cyc(20); rst_en = '0;
        pulse_halt();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) begin
                mode = 2'($urandom_range(3));
                src = ($urandom_range(3) == 0);
                pre = 16'($urandom_range(2));
                mv[3] = 16'($urandom_range(12));
                for (int k = 0; k < NCH-1; k++) mv[k] = 16'($urandom_range(15));
                irq_en = 4'($urandom_range(15));
                rst_en = ($urandom_range(3) == 0) ? 4'($urandom_range(15)) : '0;
                stop_en = ($urandom_range(3) == 0) ? 4'($urandom_range(15)) : '0;
                pwm_en = 4'($urandom_range(15));
                act = 8'($urandom_range(255));
                out_en = 4'($urandom_range(15));
                gpio = 4'($urandom_range(15));
            end
            t_start = ($urandom_range(7) == 0);
            t_halt  = ($urandom_range(39) == 0);
            t_clr   = ($urandom_range(49) == 0);
            fclr    = ($urandom_range(3) == 0) ? 4'($urandom_range(15)) : '0;
            cap     = 1'($urandom_range(1));
            cyc(1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule